// File: doc/BRIEF.md
# Write-Once Configuration Word Bank

This block holds three 32-bit configuration words that behave like one-time-programmable storage on a small memory-mapped bus. One word controls access by an external debugger. The other two are free user data, such as a unique node address or a calibration tag. Every word leaves the factory in its erased state. It takes exactly one write. Bit 31 of each word is a hardware-managed blank flag: it reads 1 until the word is written, and it is forced to 0 by that write. From then on the word is frozen. Any further write to it is refused and reported by a one-cycle error pulse.

The debug word drives a registered `debugEnable` output. This output is only re-evaluated when a power-up pulse arrives, so programming the debug word has no visible effect until the next power-up. The storage is modelled as flops that survive power-up pulses. Only the factory-erase input clears them. Reads are combinational, and unmapped offsets read as zero.

Top module: `otp_cfg_bank`

## Requirements
- R1: While or after `factoryErase` is held high for a clock edge, the word at offset 0x00 reads 0xFFFFFFFE, the words at offsets 0x10 and 0x14 read 0xFFFFFFFF, and both `debugEnable` and `wrErr` are 0.
- R2: `rdData` shows the word at `rdAddr` in the same cycle the address is presented. Any offset other than 0x00, 0x10 and 0x14 reads 0.
- R3: A write to a word whose bit 31 is 1 stores `wrData[30:0]` in bits 30:0 and 0 in bit 31, whatever `wrData[31]` holds. The stored value is visible from the cycle after the write edge.
- R4: A write to a word whose bit 31 is 0 leaves the word unchanged. `wrErr` is then 1 for exactly the one cycle following the write edge.
- R5: On a `powerUp` pulse, `debugEnable` loads 1 if bit 1 of the debug word (offset 0x00) is 1 and bit 0 is 0, and loads 0 otherwise. The new value is visible from the cycle after the pulse edge.
- R6: Between power-up pulses `debugEnable` holds its value. In particular, a write that clears bit 1 of the debug word leaves it unchanged until the next pulse.
- R7: A power-up pulse never changes the stored words. Only `factoryErase` returns them to the values of R1.
- R8: A write presented in the same cycle as `powerUp` is ignored and raises no `wrErr`.
- R9: A write to an unmapped offset changes no word and raises no `wrErr`.
- R10: Each word locks independently: writing one word leaves the others blank and writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| factoryErase | input | 1 | Synchronous, active high; restores every word to its erased value |
| powerUp | input | 1 | One-cycle pulse marking a power-up; samples the debug condition |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 8 | Byte offset of the write |
| wrData | input | 32 | Write data |
| rdAddr | input | 8 | Byte offset of the combinational read |
| rdData | output | 32 | Word at `rdAddr`, or 0 when unmapped |
| wrErr | output | 1 | One-cycle pulse after a refused write to a locked word |
| debugEnable | output | 1 | Debugger access permitted, as sampled at the last power-up |

## Verification
The hardest state to reach is the gap between programming the debug word and the next power-up. In that gap the stored bits already deny debug access, but `debugEnable` must still show the old decision. The stimulus sets up this gap on purpose. It first writes a value that clears bit 1 and checks that `debugEnable` is still 1 several cycles later. Only then does it issue a power-up pulse.

A second awkward case is a write that coincides with a power-up pulse, which is driven as a single combined cycle. After a factory erase, the bench writes a value with both control bits set, to show that bit 0 alone also closes access.

// File: rtl/otp_cfg_pkg.sv
package otp_cfg_pkg;

  localparam int WORD_W      = 32;
  localparam int NUM_WORDS   = 3;
  localparam int OFFS_W      = 8;
  localparam int LOCK_BIT    = WORD_W - 1;
  localparam int DBG_WORD    = 0;
  localparam int DBG_KEEP_HI = 1;   // must be 1 for debug access
  localparam int DBG_KEEP_LO = 0;   // must be 0 for debug access
  localparam int USER_BASE   = 16;  // first user word at byte 0x10
  localparam int WORD_BYTES  = 4;

  // Strobes handed from control to datapath each cycle
  typedef struct packed {
    logic [NUM_WORDS-1:0] wrSel;    // accepted write, one bit per word
    logic                 wrReject; // write hit a locked word
    logic                 dbgLoad;  // resample the debug condition
  } ctrlStrobes_t;

  function automatic logic [OFFS_W-1:0] wordOffset(input int idx);
    int byteOffs;
    if (idx == DBG_WORD) byteOffs = 0;
    else                 byteOffs = USER_BASE + WORD_BYTES * (idx - 1);
    return OFFS_W'(byteOffs);
  endfunction

  function automatic logic [WORD_W-1:0] eraseValue(input int idx);
    logic [WORD_W-1:0] v;
    v = '1;
    if (idx == DBG_WORD) v[DBG_KEEP_LO] = 1'b0;
    return v;
  endfunction

endpackage

// File: rtl/otp_cfg_ctrl.sv
module otp_cfg_ctrl
  import otp_cfg_pkg::*;
(
  input  logic                 factoryErase,
  input  logic                 powerUp,
  input  logic                 wrEn,
  input  logic [OFFS_W-1:0]    wrAddr,
  input  logic [NUM_WORDS-1:0] blankFlags,
  output ctrlStrobes_t         strobes
);

  logic [NUM_WORDS-1:0] addrHit;
  logic                 busQuiet;
  logic                 wrLive;

  genvar g;
  generate
    for (g = 0; g < NUM_WORDS; g++) begin : g_dec
      assign addrHit[g] = (wrAddr == wordOffset(g));
    end
  endgenerate

  // Erase and power-up own the cycle; the bus is dead then (R8)
  assign busQuiet = factoryErase | powerUp;
  assign wrLive   = wrEn & ~busQuiet;

  always_comb begin
    strobes          = '0;
    strobes.wrSel    = wrLive ? (addrHit & blankFlags) : '0;
    strobes.wrReject = wrLive & (|(addrHit & ~blankFlags));
    strobes.dbgLoad  = powerUp & ~factoryErase;
  end

endmodule

// File: rtl/otp_cfg_dp.sv
module otp_cfg_dp
  import otp_cfg_pkg::*;
(
  input  logic                 clk,
  input  logic                 factoryErase,
  input  ctrlStrobes_t         strobes,
  input  logic [WORD_W-1:0]    wrData,
  input  logic [OFFS_W-1:0]    rdAddr,
  output logic [WORD_W-1:0]    rdData,
  output logic [NUM_WORDS-1:0] blankFlags,
  output logic                 wrErr,
  output logic                 debugEnable
);

  logic [WORD_W-1:0] words [NUM_WORDS];
  logic              dbgOpen;

  genvar g;
  generate
    for (g = 0; g < NUM_WORDS; g++) begin : g_word
      always_ff @(posedge clk) begin
        if (factoryErase)
          words[g] <= eraseValue(g);
        else if (strobes.wrSel[g])
          words[g] <= {1'b0, wrData[WORD_W-2:0]};
      end
      assign blankFlags[g] = words[g][LOCK_BIT];

      // R4: a locked word never moves until erase
      p_locked_stable_r4: assert property (@(posedge clk) disable iff (factoryErase)
        !words[g][LOCK_BIT] |=> $stable(words[g]));
      // R3: accepted write lands with the lock flag cleared
      p_accept_store_r3: assert property (@(posedge clk) disable iff (factoryErase)
        strobes.wrSel[g] |=> (words[g] == {1'b0, $past(wrData[WORD_W-2:0])}));
      // R7: power-up leaves storage untouched
      p_pu_keeps_r7: assert property (@(posedge clk) disable iff (factoryErase)
        strobes.dbgLoad |=> $stable(words[g]));
    end
  endgenerate

  assign dbgOpen = words[DBG_WORD][DBG_KEEP_HI] & ~words[DBG_WORD][DBG_KEEP_LO];

  always_ff @(posedge clk) begin
    if (factoryErase)         debugEnable <= 1'b0;
    else if (strobes.dbgLoad) debugEnable <= dbgOpen;
  end

  always_ff @(posedge clk) begin
    if (factoryErase) wrErr <= 1'b0;
    else              wrErr <= strobes.wrReject;
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_WORDS; i++)
      if (rdAddr == wordOffset(i)) rdData = words[i];
  end

  // R6: no drift of the debug output between pulses
  p_dbg_hold_r6: assert property (@(posedge clk) disable iff (factoryErase)
    !strobes.dbgLoad |=> $stable(debugEnable));
  // R5: pulse samples the stored control bits
  p_dbg_load_r5: assert property (@(posedge clk) disable iff (factoryErase)
    strobes.dbgLoad |=> (debugEnable ==
      ($past(words[DBG_WORD][DBG_KEEP_HI]) && !$past(words[DBG_WORD][DBG_KEEP_LO]))));

endmodule

// File: rtl/otp_cfg_bank.sv
module otp_cfg_bank
  import otp_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              factoryErase,
  input  logic              powerUp,
  input  logic              wrEn,
  input  logic [OFFS_W-1:0] wrAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic [OFFS_W-1:0] rdAddr,
  output logic [WORD_W-1:0] rdData,
  output logic              wrErr,
  output logic              debugEnable
);

  ctrlStrobes_t         strobes;
  logic [NUM_WORDS-1:0] blankFlags;

  otp_cfg_ctrl u_ctrl (
    .factoryErase (factoryErase),
    .powerUp      (powerUp),
    .wrEn         (wrEn),
    .wrAddr       (wrAddr),
    .blankFlags   (blankFlags),
    .strobes      (strobes)
  );

  otp_cfg_dp u_dp (
    .clk          (clk),
    .factoryErase (factoryErase),
    .strobes      (strobes),
    .wrData       (wrData),
    .rdAddr       (rdAddr),
    .rdData       (rdData),
    .blankFlags   (blankFlags),
    .wrErr        (wrErr),
    .debugEnable  (debugEnable)
  );

  // R4: a bus write to the locked debug word yields an error pulse
  p_reject_pulse_r4: assert property (@(posedge clk) disable iff (factoryErase)
    (wrEn && !powerUp && wrAddr == wordOffset(DBG_WORD) && !blankFlags[DBG_WORD]) |=> wrErr);
  // R8/R9: the error pulse only follows a live bus write
  p_err_cause_r9: assert property (@(posedge clk) disable iff (factoryErase)
    wrErr |-> ($past(wrEn) && !$past(powerUp)));

endmodule

// File: tb/tb_otp_cfg_bank.sv
`timescale 1ns/1ps
module tb_otp_cfg_bank;

  logic        clk = 1'b0;
  logic        factoryErase = 1'b1;
  logic        powerUp = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [7:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic        wrErr;
  logic        debugEnable;

  always #2 clk = ~clk;  // 250 MHz

  otp_cfg_bank dut (
    .clk(clk), .factoryErase(factoryErase), .powerUp(powerUp),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .wrErr(wrErr), .debugEnable(debugEnable)
  );

  typedef enum logic [1:0] {K_RD, K_ERR, K_DBG} kind_t;
  typedef struct {
    kind_t       kind;
    logic [7:0]  addr;
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t       sb[$];
  int          compared = 0;
  int          mismatched = 0;
  bit          done = 1'b0;
  logic [31:0] mdl [3];
  logic        dbgMdl = 1'b0;

  function automatic int slotOf(input logic [7:0] a);
    case (a)
      8'h00:   return 0;
      8'h10:   return 1;
      8'h14:   return 2;
      default: return -1;
    endcase
  endfunction

  function automatic void push(input kind_t k, input logic [7:0] a,
                               input logic [31:0] e, input string r);
    item_t it;
    it.kind = k; it.addr = a; it.exp = e; it.req = r;
    sb.push_back(it);
  endfunction

  // Monitor: compares queued expectations 1 ns after each falling edge
  initial forever begin
    @(negedge clk);
    #1;
    while (sb.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb.pop_front();
      case (it.kind)
        K_RD:    act = rdData;
        K_ERR:   act = {31'b0, wrErr};
        default: act = {31'b0, debugEnable};
      endcase
      compared++;
      if (act !== it.exp) begin
        mismatched++;
        $display("FAIL %s kind=%s addr=0x%02h actual=0x%08h expected=0x%08h",
                 it.req, it.kind.name(), it.addr, act, it.exp);
      end
    end
  end

  task automatic readChk(input logic [7:0] a, input string r);
    int k;
    k = slotOf(a);
    @(negedge clk);
    rdAddr = a;
    push(K_RD, a, (k >= 0) ? mdl[k] : 32'h0, r);
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d,
                          input bit withPu, input string r);
    int   k;
    logic expErr;
    k = slotOf(a);
    expErr = 1'b0;
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d; powerUp = withPu;
    if (withPu) dbgMdl = mdl[0][1] & ~mdl[0][0];
    else if (k >= 0) begin
      if (mdl[k][31]) mdl[k] = {1'b0, d[30:0]};
      else            expErr = 1'b1;
    end
    @(negedge clk);
    wrEn = 1'b0; powerUp = 1'b0;
    push(K_ERR, a, {31'b0, expErr}, r);
    if (withPu) push(K_DBG, a, {31'b0, dbgMdl}, r);
    @(negedge clk);
    push(K_ERR, a, 32'h0, r);  // pulse lasts a single cycle
  endtask

  task automatic pulsePowerUp(input string r);
    @(negedge clk);
    powerUp = 1'b1;
    dbgMdl = mdl[0][1] & ~mdl[0][0];
    @(negedge clk);
    powerUp = 1'b0;
    push(K_DBG, 8'h00, {31'b0, dbgMdl}, r);
  endtask

  task automatic dbgChk(input string r);
    @(negedge clk);
    push(K_DBG, 8'h00, {31'b0, dbgMdl}, r);
  endtask

  task automatic doErase();
    @(negedge clk); factoryErase = 1'b1;
    @(negedge clk);
    @(negedge clk); factoryErase = 1'b0;
    mdl[0] = 32'hFFFF_FFFE; mdl[1] = 32'hFFFF_FFFF; mdl[2] = 32'hFFFF_FFFF;
    dbgMdl = 1'b0;
  endtask

  task automatic readAll(input string r);
    readChk(8'h00, r); readChk(8'h10, r); readChk(8'h14, r);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    doErase();
    // R1 reset state
    readAll("R1");
    dbgChk("R1");
    @(negedge clk); push(K_ERR, 8'h00, 32'h0, "R1");
    // R2 unmapped reads
    readChk(8'h04, "R2"); readChk(8'h1C, "R2"); readChk(8'hFF, "R2");
    // R5 factory control bits open debug
    pulsePowerUp("R5");
    // R3 first write to a user word
    busWrite(8'h10, 32'h1234_5678, 1'b0, "R3");
    readChk(8'h10, "R3");
    // R10 other words remain blank
    readChk(8'h14, "R10"); readChk(8'h00, "R10");
    // R4 second write refused
    busWrite(8'h10, 32'hAAAA_AAAA, 1'b0, "R4");
    readChk(8'h10, "R4");
    // R9 unmapped write ignored
    busWrite(8'h08, 32'h0000_0000, 1'b0, "R9");
    readAll("R9");
    // R6 clearing bit 1 does not close debug yet
    busWrite(8'h00, 32'hFFFF_FFFD, 1'b0, "R6");
    readChk(8'h00, "R3");
    repeat (3) dbgChk("R6");
    pulsePowerUp("R5");
    dbgChk("R6");
    // R7 storage survives power-up
    readAll("R7");
    // R4 debug word locked too
    busWrite(8'h00, 32'hFFFF_FFFE, 1'b0, "R4");
    readChk(8'h00, "R4");
    // R8 write during power-up is dropped
    busWrite(8'h14, 32'h0F0F_0F0F, 1'b1, "R8");
    readChk(8'h14, "R8");
    // R3 bit 31 of data is forced to 0
    busWrite(8'h14, 32'hFFFF_FFFF, 1'b0, "R3");
    readChk(8'h14, "R3");
    busWrite(8'h14, 32'h0, 1'b0, "R4");
    // R1/R7 erase restores factory values
    doErase();
    readAll("R7");
    dbgChk("R1");
    pulsePowerUp("R5");
    // R5 bit 0 set also closes debug
    busWrite(8'h00, 32'h0000_0003, 1'b0, "R5");
    dbgChk("R6");
    pulsePowerUp("R5");
    readChk(8'h00, "R3");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule